// File: doc/BRIEF.md
# Buffer Permission Checker for Region-Based Memory Protection

This block answers one question: may a software buffer, given by its first byte address, its length in bytes and a read or write flag, be touched under the current set of memory protection entries? Each entry holds an 8-bit configuration byte and an address register that stores a byte address shifted right by two. The configuration byte picks how the address register is turned into a byte range: the entry can be switched off, it can cover the span that begins where the previous entry's register points, it can cover a naturally aligned block of four bytes, or it can cover a naturally aligned power-of-two block.

A request is taken with a valid/ready handshake. The block then walks the entries from index 0 upward, one entry per clock. The first entry whose range holds the whole buffer settles the answer from its read or write bit, and the walk stops there. If the walk runs off the end, the request is refused. Entries whose index is below a parameterised static count read their contents from the hardware register bank, and every other index reads from the per-thread shadow bank. Both banks arrive as flat input vectors.

Top module: `pmp_buf_check`

## Requirements
- R1: Bits [4:3] of a configuration byte hold the mode: 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two. An entry in mode 0 never matches, whatever its permission bits.
- R2: Bit 0 of a configuration byte grants read and bit 1 grants write. A write request looks only at bit 1 and a read request looks only at bit 0.
- R3: A four-byte entry covers byte addresses reg*4 through reg*4+3.
- R4: For a power-of-two entry, let t be the number of consecutive ones in the register counted up from bit 0, and let mask = 2^(t+1)-1. The region starts at (reg & ~mask)*4 and ends at ((reg | mask)*4)+3.
- R5: A top-of-range entry covers prev*4 through reg*4-1, where prev is the address register of the entry one index lower, and 0 for entry 0. If the register is 0 or the end falls below the start, the region is empty.
- R6: The buffer's last byte is start+len-1, and is start when len is 0. If that sum carries out of the address width, no entry matches.
- R7: An entry matches only when start is at or above the region start and the last byte is at or below the region end.
- R8: The lowest-indexed matching entry alone decides the result. Its permission bit gives grant or deny, and no higher entry is looked at.
- R9: When no entry matches, the answer is deny.
- R10: Index i reads its configuration and register from the hardware bank when i < STATIC_CNT, and from the shadow bank otherwise.
- R11: `req_ready` is high only while idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. `rsp_done` pulses for one cycle, k+1 cycles after acceptance when entry k decides, or NUM_ENTRIES cycles after acceptance when none matches. `rsp_grant` is low whenever `rsp_done` is low.
- R12: After reset `req_ready` is 1 and `rsp_done` and `rsp_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_start | input | AW | First byte address of the buffer |
| req_len | input | AW | Buffer length in bytes |
| req_write | input | 1 | 1 = write access, 0 = read access |
| hw_cfg | input | NUM_ENTRIES*8 | Hardware bank configuration bytes, entry i at [8i+7:8i] |
| hw_addr | input | NUM_ENTRIES*AW | Hardware bank address registers, entry i at [AW*i +: AW] |
| sh_cfg | input | NUM_ENTRIES*8 | Shadow bank configuration bytes |
| sh_addr | input | NUM_ENTRIES*AW | Shadow bank address registers |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_grant | output | 1 | Access allowed, valid with rsp_done |

## Verification
The bench loads one table of entries that mixes every mode. It places deliberately conflicting decoys in the bank that must be ignored: an all-covering entry in the shadow slot at index 0 and in the hardware slots at higher indices. Buffers are chosen to fall exactly on region edges and one byte past them. This separates off-by-one errors in the four-byte, power-of-two and top-of-range decoders, and shows whether the wrong bank was read. Overlapping entries with opposite permissions show whether the lowest index wins. Zero-length, top-of-address-space and wrapping buffers exercise the end-address rule. The response latency is checked on every request, which confirms which entry decided. A directed case with a top-of-range entry 0 whose register is zero confirms that an empty region is never taken as a match.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
  localparam int CFG_BIT_R    = 0;
  localparam int CFG_BIT_W    = 1;
  localparam int CFG_MODE_LSB = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/pmp_bank_sel.sv
module pmp_bank_sel #(
  parameter int NUM_ENTRIES = 8,
  parameter int AW          = 32,
  parameter int STATIC_CNT  = 1,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES*8-1:0]  hw_cfg,
  input  logic [NUM_ENTRIES*AW-1:0] hw_addr,
  input  logic [NUM_ENTRIES*8-1:0]  sh_cfg,
  input  logic [NUM_ENTRIES*AW-1:0] sh_addr,
  input  logic [IW-1:0]             idx,
  output logic [7:0]                cur_cfg,
  output logic [AW-1:0]             cur_addr,
  output logic [AW-1:0]             prev_addr
);
  logic [7:0]    sel_cfg  [NUM_ENTRIES];
  logic [AW-1:0] sel_addr [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    if (g < STATIC_CNT) begin : g_hw
      logic unused_sh;
      assign unused_sh   = ^{sh_cfg[8*g +: 8], sh_addr[AW*g +: AW]};
      assign sel_cfg[g]  = hw_cfg[8*g +: 8];
      assign sel_addr[g] = hw_addr[AW*g +: AW];
    end else begin : g_sh
      logic unused_hw;
      assign unused_hw   = ^{hw_cfg[8*g +: 8], hw_addr[AW*g +: AW]};
      assign sel_cfg[g]  = sh_cfg[8*g +: 8];
      assign sel_addr[g] = sh_addr[AW*g +: AW];
    end
  end

  always_comb begin
    cur_cfg   = sel_cfg[idx];
    cur_addr  = sel_addr[idx];
    prev_addr = (idx == '0) ? '0 : sel_addr[idx - IW'(1)];
  end
endmodule

// File: rtl/pmp_region_decode.sv
module pmp_region_decode
  import pmp_chk_pkg::*;
#(
  parameter int AW = 32,
  localparam int XW = AW + 3
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] prev_addr,
  output logic          region_ok,
  output logic [XW-1:0] region_lo,
  output logic [XW-1:0] region_hi
);
  logic [AW:0]   napot_mask;
  logic [XW-1:0] addr_x;
  logic [XW-1:0] prev_x;

  // Prefix AND of the register bits: mask bit j is set while bits below j are all ones.
  always_comb begin
    logic run;
    run = 1'b1;
    for (int j = 0; j < AW; j++) begin
      napot_mask[j] = run;
      run = run & addr[j];
    end
    napot_mask[AW] = run;
  end

  assign addr_x = {3'b000, addr} << 2;
  assign prev_x = {3'b000, prev_addr} << 2;

  always_comb begin
    region_ok = 1'b0;
    region_lo = '0;
    region_hi = '0;
    case (match_mode_e'(mode))
      MODE_NA4: begin
        region_ok = 1'b1;
        region_lo = addr_x;
        region_hi = addr_x + XW'(3);
      end
      MODE_NAPOT: begin
        region_ok = 1'b1;
        region_lo = {2'b00, ({1'b0, addr} & ~napot_mask)} << 2;
        region_hi = ({2'b00, ({1'b0, addr} | napot_mask)} << 2) | XW'(3);
      end
      MODE_TOR: begin
        region_lo = prev_x;
        region_hi = addr_x - XW'(1);
        region_ok = (addr != '0) && (addr_x - XW'(1) >= prev_x);
      end
      default: region_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_buf_check.sv
module pmp_buf_check
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int AW          = 32,
  parameter int STATIC_CNT  = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_start,
  input  logic [AW-1:0]             req_len,
  input  logic                      req_write,
  input  logic [NUM_ENTRIES*8-1:0]  hw_cfg,
  input  logic [NUM_ENTRIES*AW-1:0] hw_addr,
  input  logic [NUM_ENTRIES*8-1:0]  sh_cfg,
  input  logic [NUM_ENTRIES*AW-1:0] sh_addr,
  output logic                      rsp_done,
  output logic                      rsp_grant
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int XW = AW + 3;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_ENTRIES - 1);

  scan_state_e   state_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] len_q;
  logic          wr_q;

  logic [7:0]    cur_cfg;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] prev_addr;
  logic          region_ok;
  logic [XW-1:0] region_lo;
  logic [XW-1:0] region_hi;

  pmp_bank_sel #(
    .NUM_ENTRIES(NUM_ENTRIES), .AW(AW), .STATIC_CNT(STATIC_CNT)
  ) u_sel (
    .hw_cfg(hw_cfg), .hw_addr(hw_addr), .sh_cfg(sh_cfg), .sh_addr(sh_addr),
    .idx(idx_q), .cur_cfg(cur_cfg), .cur_addr(cur_addr), .prev_addr(prev_addr)
  );

  pmp_region_decode #(.AW(AW)) u_dec (
    .mode(cur_cfg[CFG_MODE_LSB +: 2]), .addr(cur_addr), .prev_addr(prev_addr),
    .region_ok(region_ok), .region_lo(region_lo), .region_hi(region_hi)
  );

  // Buffer end with carry bit; a carry means the buffer wraps.
  logic [AW:0]   buf_last;
  logic          buf_wraps;
  logic          hit;
  logic          perm_ok;
  logic          unused_cfg;

  assign buf_last  = {1'b0, start_q} + {1'b0, (len_q == '0) ? len_q : len_q - AW'(1)};
  assign buf_wraps = buf_last[AW];
  assign hit       = region_ok && !buf_wraps
                  && ({3'b000, start_q} >= region_lo)
                  && ({2'b00, buf_last} <= region_hi);
  assign perm_ok   = wr_q ? cur_cfg[CFG_BIT_W] : cur_cfg[CFG_BIT_R];
  assign unused_cfg = ^{cur_cfg[7:5], cur_cfg[2]};

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      start_q   <= '0;
      len_q     <= '0;
      wr_q      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_grant <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            start_q <= req_start;
            len_q   <= req_len;
            wr_q    <= req_write;
            idx_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        default: begin
          if (hit) begin
            rsp_done  <= 1'b1;
            rsp_grant <= perm_ok;
            state_q   <= ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            rsp_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pmp_buf_check_sva.sv
module pmp_buf_check_sva #(
  parameter int NUM_ENTRIES = 8,
  parameter int AW          = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_start,
  input logic [AW-1:0] req_len,
  input logic          rsp_done,
  input logic          rsp_grant
);
  logic [AW-1:0] s_q;
  logic [AW-1:0] l_q;
  logic [15:0]   busy_cnt;
  logic [AW:0]   end_chk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
      l_q <= '0;
      busy_cnt <= '0;
    end else if (req_valid && req_ready) begin
      s_q <= req_start;
      l_q <= req_len;
      busy_cnt <= 16'd1;
    end else if (!req_ready) begin
      busy_cnt <= busy_cnt + 16'd1;
    end
  end

  assign end_chk = {1'b0, s_q} + {1'b0, l_q} - ((l_q == '0) ? '0 : {{AW{1'b0}}, 1'b1});

  // R11: result strobe lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done);
  // R11: block is idle when it reports
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst) rsp_done |-> req_ready);
  // R11: an accepted request makes the block busy
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R11: grant is never shown without the strobe
  p_grant_gated_r11: assert property (@(posedge clk) disable iff (rst) !rsp_done |-> !rsp_grant);
  // R11: a scan never exceeds one cycle per entry
  p_scan_bound_r11: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (busy_cnt <= 16'(NUM_ENTRIES)));
  // R6: a wrapping buffer is never granted
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_grant) |-> !end_chk[AW]);
endmodule

bind pmp_buf_check pmp_buf_check_sva #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_start(req_start), .req_len(req_len), .rsp_done(rsp_done), .rsp_grant(rsp_grant)
);

// File: tb/pmp_buf_check_tb.sv
module pmp_buf_check_tb;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_len = '0;
  logic req_write = 1'b0;
  logic [N*8-1:0]  hw_cfg, sh_cfg;
  logic [N*AW-1:0] hw_addr, sh_addr;
  logic rsp_done, rsp_grant;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pmp_buf_check #(.NUM_ENTRIES(N), .AW(AW), .STATIC_CNT(1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_len(req_len), .req_write(req_write),
    .hw_cfg(hw_cfg), .hw_addr(hw_addr), .sh_cfg(sh_cfg), .sh_addr(sh_addr),
    .rsp_done(rsp_done), .rsp_grant(rsp_grant)
  );

  // {start, len, write, exp_grant, exp_cycles, req_tag}
  localparam logic [73:0] VEC [NV] = '{
    {32'h0000_0400, 32'd4,     1'b0, 1'b1, 4'd1, 4'd3},  // R3 four-byte read ok
    {32'h0000_0400, 32'd4,     1'b1, 1'b0, 4'd1, 4'd10}, // R10 shadow decoy ignored, R2
    {32'h0000_0402, 32'd4,     1'b0, 1'b0, 4'd8, 4'd10}, // R10 hw decoys ignored, R9
    {32'h0000_1000, 32'h100,   1'b1, 1'b1, 4'd2, 4'd4},  // R4 whole block write
    {32'h0000_1000, 32'h100,   1'b0, 1'b0, 4'd2, 4'd2},  // R2 no read bit
    {32'h0000_1080, 32'h10,    1'b0, 1'b0, 4'd2, 4'd8},  // R8 entry 1 beats entry 2
    {32'h0000_1100, 32'h10,    1'b0, 1'b1, 4'd3, 4'd5},  // R5 range read
    {32'h0000_10F0, 32'h20,    1'b1, 1'b0, 4'd3, 4'd2},  // R2 write on read-only range
    {32'h0000_1FFF, 32'd1,     1'b0, 1'b1, 4'd3, 4'd5},  // R5 top byte
    {32'h0000_1FFF, 32'd2,     1'b0, 1'b0, 4'd8, 4'd7},  // R7 one byte over
    {32'h0000_2000, 32'd1,     1'b0, 1'b0, 4'd8, 4'd5},  // R5 empty range
    {32'h0000_C000, 32'd4,     1'b0, 1'b0, 4'd8, 4'd1},  // R1 off entry with perms
    {32'h0000_8000, 32'd0,     1'b1, 1'b1, 4'd6, 4'd6},  // R6 zero length
    {32'h0000_8003, 32'd1,     1'b0, 1'b1, 4'd6, 4'd3},  // R3 last byte
    {32'h0000_8003, 32'd2,     1'b0, 1'b0, 4'd8, 4'd3},  // R3 past four bytes
    {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 4'd7, 4'd4}, // R4 upper half
    {32'hFFFF_FFF0, 32'h10,    1'b0, 1'b1, 4'd7, 4'd6},  // R6 ends at top
    {32'hFFFF_FFF0, 32'h11,    1'b0, 1'b0, 4'd8, 4'd6},  // R6 wraps
    {32'hFFFF_FFF0, 32'h10,    1'b1, 1'b0, 4'd7, 4'd2},  // R2 write denied
    {32'h7FFF_FFFF, 32'd2,     1'b0, 1'b0, 4'd8, 4'd7},  // R7 straddles base
    {32'h0000_0FFF, 32'd2,     1'b0, 1'b0, 4'd8, 4'd7}   // R7 below start
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] s, input logic [AW-1:0] l, input logic w,
                         output logic g, output int cyc, output logic busy_seen);
    @(negedge clk);
    req_valid = 1'b1; req_start = s; req_len = l; req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    cyc = 0;
    while (!rsp_done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    g = rsp_grant;
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic g;
    logic busy;
    int cyc;
    // hw bank: entry 0 four-byte at 0x400 read-only; others all-covering decoys
    hw_cfg = '0; hw_addr = '0; sh_cfg = '0; sh_addr = '0;
    hw_cfg[0 +: 8] = 8'h11; hw_addr[0 +: AW] = 32'h100;
    for (int i = 1; i < N; i++) begin
      hw_cfg[8*i +: 8] = 8'h1B; hw_addr[AW*i +: AW] = '1;
    end
    sh_cfg[0 +: 8]  = 8'h1B; sh_addr[0 +: AW]    = '1;           // decoy
    sh_cfg[8 +: 8]  = 8'h1A; sh_addr[AW +: AW]   = 32'h41F;      // 0x1000..0x10FF W
    sh_cfg[16 +: 8] = 8'h09; sh_addr[2*AW +: AW] = 32'h800;      // 0x107C..0x1FFF R
    sh_cfg[24 +: 8] = 8'h0B; sh_addr[3*AW +: AW] = 32'h700;      // empty range
    sh_cfg[32 +: 8] = 8'h03; sh_addr[4*AW +: AW] = 32'h3000;     // off
    sh_cfg[40 +: 8] = 8'h13; sh_addr[5*AW +: AW] = 32'h2000;     // 0x8000..0x8003 RW
    sh_cfg[48 +: 8] = 8'h19; sh_addr[6*AW +: AW] = 32'h2FFF_FFFF;// upper half R
    sh_cfg[56 +: 8] = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);
    check(rsp_done == 1'b0, "R12 done after reset", rsp_done, 0);
    check(rsp_grant == 1'b0, "R12 grant after reset", rsp_grant, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][73:42], VEC[v][41:10], VEC[v][9], g, cyc, busy);
      total++;
      if (g !== VEC[v][8]) begin
        fails++;
        $display("FAIL R%0d vector %0d grant actual=%0d expected=%0d", VEC[v][3:0], v, g, VEC[v][8]);
      end
      check(cyc == int'(VEC[v][7:4]), "R11 latency", cyc, int'(VEC[v][7:4]));
    end

    // R11 busy while scanning, one-cycle strobe, grant gated
    run_req(32'h400, 32'd4, 1'b0, g, cyc, busy);
    check(busy == 1'b1, "R11 ready low during scan", !busy, 0);
    check(req_ready == 1'b1, "R11 ready with done", req_ready, 1);
    @(negedge clk);
    check(rsp_done == 1'b0, "R11 done one cycle", rsp_done, 0);
    check(rsp_grant == 1'b0, "R11 grant low without done", rsp_grant, 0);

    // R5 top-of-range entry 0 with zero register is empty
    hw_cfg[0 +: 8] = 8'h0B; hw_addr[0 +: AW] = '0;
    run_req(32'h10, 32'd4, 1'b0, g, cyc, busy);
    check(g == 1'b0, "R5 empty entry-0 range grant", g, 0);
    check(cyc == N, "R5 empty entry-0 range latency", cyc, N);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule